// File: doc/BRIEF.md
# Calendar Counter with Daylight Saving

This block keeps wall-clock time and date in separate binary fields: seconds, minutes, hours, day of month, day of week, month and an eight-bit year offset. A one-cycle pulse on `tick_1hz` advances the whole chain by one second. Carries ripple from seconds up to the year in the same clock edge. Month lengths follow the Gregorian calendar, and a year offset divisible by four is treated as a leap year.

Software can load any field through a single write port. It can also nudge the seconds up or down by one. A daylight-saving unit holds a start point and an end point, each given as month, day and hour. When the feature is enabled, the unit moves the hour forward on reaching the start point. On reaching the end point it moves the hour back exactly once. A `busy` flag marks the cycle in which the counters have just changed. Any read or write that arrives while `busy` is high sets a sticky bus-error flag.

Top module: `cal_dst_clock`

## Requirements
- R1: After reset the time reads 00:00:00, day 1, month 1, year 0, day-of-week 0. `busy`, `bus_err` and `dst_active` are all 0.
- R2: A `tick_1hz` pulse that is not overridden adds one second. Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0 and carry into the day.
- R3: The day wraps to 1 after the month's last day: 31, 30 for months 4, 6, 9 and 11, and for month 2 either 28 or 29 (29 when the year offset mod 4 is 0). The month then advances, wrapping from 12 to 1. When the month wraps, the year offset increments, wrapping from 255 to 0.
- R4: Day-of-week advances by one on every day rollover, wrapping from 6 to 0.
- R5: `wr_en` loads the low bits of `wr_data` into the field chosen by `wr_sel`: 0 seconds, 1 minutes, 2 hours, 3 day, 4 day-of-week, 5 month, 6 year. A write to codes 0 to 6 in the same cycle as a tick wins, and that tick is discarded.
- R6: `inc_sec` alone moves seconds up by one, wrapping 59 to 0. `dec_sec` alone moves seconds down by one, wrapping 0 to 59. Neither carries into the minutes. Both strobes together leave the time unchanged. Any strobe discards a tick in the same cycle.
- R7: While `dst_en` is 1 and `dst_active` is 0, a tick that carries into a new hour equal to the start month, day and hour sets the hour one higher and sets `dst_active`. With `dst_en` at 0, no shift occurs.
- R8: While `dst_active` is 1, a tick carrying into the end month, day and hour sets the hour one lower and clears `dst_active`. The same hour reached again does not shift a second time.
- R9: Codes 7 to 12 of `wr_sel` write the start month, start day, start hour, end month, end day and end hour. These writes are ignored while `dst_en` is 1. Lowering `dst_en` clears `dst_active` on the next edge.
- R10: `busy` is 1 for the one cycle after an accepted tick and 0 otherwise.
- R11: `rd_en` or `wr_en` while `busy` is 1 sets `bus_err` on the next edge. `bus_err` stays set until `berr_clr` is applied. A set and a clear in the same cycle leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 4 | Field select code |
| wr_data | input | 8 | Write value (low bits used) |
| rd_en | input | 1 | Read access strobe, for bus-error tracking |
| inc_sec | input | 1 | Seconds plus-one strobe |
| dec_sec | input | 1 | Seconds minus-one strobe |
| dst_en | input | 1 | Daylight-saving enable |
| berr_clr | input | 1 | Clears the bus-error flag |
| cnt_sec | output | 6 | Seconds |
| cnt_minute | output | 6 | Minutes |
| cnt_hour | output | 5 | Hours |
| cnt_day | output | 5 | Day of month |
| cnt_dow | output | 3 | Day of week |
| cnt_month | output | 4 | Month |
| cnt_year | output | 8 | Year offset |
| dst_active | output | 1 | Daylight-saving shift in force |
| busy | output | 1 | Counters changed last edge |
| bus_err | output | 1 | Sticky access-while-busy flag |

## Verification
A wrong carry or a wrong month length shows on the count outputs at the edge that takes the tick. The next sample away from that edge therefore exposes the fault, one cycle after the pulse. Daylight-saving state is not visible directly. A missing `dst_active` set or clear shows up one tick later as a wrong hour at the start or end point, or as a second shift when the end hour comes round again. The bench rebuilds each loaded start point. A configuration write that slipped through while enabled then shows as a shift at the wrong hour.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DAY_W  = 5;
  localparam int DOW_W  = 3;
  localparam int MON_W  = 4;
  localparam int YEAR_W = 8;

  typedef struct packed {
    logic [YEAR_W-1:0] year;
    logic [MON_W-1:0]  month;
    logic [DAY_W-1:0]  day;
    logic [DOW_W-1:0]  dow;
    logic [HOUR_W-1:0] hour;
    logic [MIN_W-1:0]  minute;
    logic [SEC_W-1:0]  sec;
  } cal_time_t;

  typedef enum logic [3:0] {
    SEL_SEC     = 4'd0,
    SEL_MIN     = 4'd1,
    SEL_HOUR    = 4'd2,
    SEL_DAY     = 4'd3,
    SEL_DOW     = 4'd4,
    SEL_MON     = 4'd5,
    SEL_YEAR    = 4'd6,
    SEL_DS_MON  = 4'd7,
    SEL_DS_DAY  = 4'd8,
    SEL_DS_HOUR = 4'd9,
    SEL_DE_MON  = 4'd10,
    SEL_DE_DAY  = 4'd11,
    SEL_DE_HOUR = 4'd12
  } wsel_e;

  // Wrapping step up: values at or above last return to zero.
  function automatic int step_up(input int v, input int last);
    return (v >= last) ? 0 : v + 1;
  endfunction

  // Wrapping step down: zero goes to last.
  function automatic int step_dn(input int v, input int last);
    return (v == 0) ? last : v - 1;
  endfunction

  // Gregorian month length; an illegal month counts as a long month.
  function automatic int month_len(input int m, input bit leap);
    case (m)
      2:             return leap ? 29 : 28;
      4, 6, 9, 11:   return 30;
      default:       return 31;
    endcase
  endfunction
endpackage

// File: rtl/cal_next.sv
module cal_next
  import cal_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int MIN_LAST  = 59,
  parameter int HOUR_LAST = 23,
  parameter int DOW_LAST  = 6,
  parameter int MON_LAST  = 12,
  parameter int LEAP_LOG2 = 2
) (
  input  cal_time_t cur,
  output cal_time_t nxt,
  output logic      hour_evt
);
  localparam int LEAP_PERIOD = 1 << LEAP_LOG2;

  logic leap;
  logic sec_c, min_c, hour_c, day_c, mon_c;

  assign leap = (int'(cur.year) % LEAP_PERIOD) == 0;

  always_comb begin
    nxt    = cur;
    sec_c  = int'(cur.sec) >= SEC_LAST;
    min_c  = sec_c && (int'(cur.minute) >= MIN_LAST);
    hour_c = min_c && (int'(cur.hour) >= HOUR_LAST);
    day_c  = hour_c && (int'(cur.day) >= month_len(int'(cur.month), leap));
    mon_c  = day_c && (int'(cur.month) >= MON_LAST);

    nxt.sec = SEC_W'(step_up(int'(cur.sec), SEC_LAST));
    if (sec_c)  nxt.minute = MIN_W'(step_up(int'(cur.minute), MIN_LAST));
    if (min_c)  nxt.hour   = HOUR_W'(step_up(int'(cur.hour), HOUR_LAST));
    if (hour_c) begin
      nxt.day = day_c ? DAY_W'(1) : cur.day + DAY_W'(1);
      nxt.dow = DOW_W'(step_up(int'(cur.dow), DOW_LAST));
    end
    if (day_c)  nxt.month = mon_c ? MON_W'(1) : cur.month + MON_W'(1);
    if (mon_c)  nxt.year  = cur.year + YEAR_W'(1);
  end

  assign hour_evt = min_c;
endmodule

// File: rtl/cal_dst.sv
module cal_dst
  import cal_pkg::*;
#(
  parameter int HOUR_LAST = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dst_en,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [DAY_W-1:0]  cfg_data,
  input  logic              hour_evt,
  input  logic [MON_W-1:0]  adv_month,
  input  logic [DAY_W-1:0]  adv_day,
  input  logic [HOUR_W-1:0] adv_hour,
  output logic [HOUR_W-1:0] hour_out,
  output logic              dst_on
);
  logic [MON_W-1:0]  s_mon, e_mon;
  logic [DAY_W-1:0]  s_day, e_day;
  logic [HOUR_W-1:0] s_hour, e_hour;
  logic start_hit, end_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_mon <= '0; s_day <= '0; s_hour <= '0;
      e_mon <= '0; e_day <= '0; e_hour <= '0;
    end else if (cfg_we && !dst_en) begin
      case (wsel_e'(cfg_sel))
        SEL_DS_MON:  s_mon  <= cfg_data[MON_W-1:0];
        SEL_DS_DAY:  s_day  <= cfg_data;
        SEL_DS_HOUR: s_hour <= cfg_data[HOUR_W-1:0];
        SEL_DE_MON:  e_mon  <= cfg_data[MON_W-1:0];
        SEL_DE_DAY:  e_day  <= cfg_data;
        SEL_DE_HOUR: e_hour <= cfg_data[HOUR_W-1:0];
        default: ;
      endcase
    end
  end

  assign start_hit = dst_en && !dst_on && hour_evt &&
                     adv_month == s_mon && adv_day == s_day && adv_hour == s_hour;
  assign end_hit   = dst_en && dst_on && hour_evt &&
                     adv_month == e_mon && adv_day == e_day && adv_hour == e_hour;

  always_comb begin
    if (start_hit)    hour_out = HOUR_W'(step_up(int'(adv_hour), HOUR_LAST));
    else if (end_hit) hour_out = HOUR_W'(step_dn(int'(adv_hour), HOUR_LAST));
    else              hour_out = adv_hour;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dst_on <= 1'b0;
    else if (!dst_en)   dst_on <= 1'b0;
    else if (start_hit) dst_on <= 1'b1;
    else if (end_hit)   dst_on <= 1'b0;
  end

  // R9
  dst_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dst_en |=> ($stable(s_mon) && $stable(s_day) && $stable(s_hour) &&
                $stable(e_mon) && $stable(e_day) && $stable(e_hour)));
  // R7
  dst_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dst_on) |-> $past(hour_evt));
  // R8
  dst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_en && !hour_evt) |=> $stable(dst_on));
endmodule

// File: rtl/cal_acc_mon.sv
module cal_acc_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_go,
  input  logic access,
  input  logic clr,
  output logic busy,
  output logic bus_err
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      busy <= tick_go;
      if (access && busy) bus_err <= 1'b1;
      else if (clr)       bus_err <= 1'b0;
    end
  end

  // R11
  berr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (access && busy) |=> bus_err);
  // R11
  berr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_err && !clr) |=> bus_err);
endmodule

// File: rtl/cal_dst_clock.sv
module cal_dst_clock
  import cal_pkg::*;
#(
  parameter int SEC_LAST  = 59,
  parameter int MIN_LAST  = 59,
  parameter int HOUR_LAST = 23,
  parameter int DOW_LAST  = 6,
  parameter int MON_LAST  = 12,
  parameter int LEAP_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              wr_en,
  input  logic [3:0]        wr_sel,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  input  logic              inc_sec,
  input  logic              dec_sec,
  input  logic              dst_en,
  input  logic              berr_clr,
  output logic [SEC_W-1:0]  cnt_sec,
  output logic [MIN_W-1:0]  cnt_minute,
  output logic [HOUR_W-1:0] cnt_hour,
  output logic [DAY_W-1:0]  cnt_day,
  output logic [DOW_W-1:0]  cnt_dow,
  output logic [MON_W-1:0]  cnt_month,
  output logic [YEAR_W-1:0] cnt_year,
  output logic              dst_active,
  output logic              busy,
  output logic              bus_err
);
  localparam cal_time_t RST_TIME = '{year: '0, month: MON_W'(1), day: DAY_W'(1),
                                     dow: '0, hour: '0, minute: '0, sec: '0};

  wsel_e       sel;
  cal_time_t   t, adv, nxt_t;
  logic        cnt_wr, up_req, dn_req, tick_go, hour_evt;
  logic [HOUR_W-1:0] hour_adj;

  assign sel     = wsel_e'(wr_sel);
  assign cnt_wr  = wr_en && (wr_sel <= 4'(SEL_YEAR));
  assign up_req  = inc_sec && !dec_sec;
  assign dn_req  = dec_sec && !inc_sec;
  assign tick_go = tick_1hz && !cnt_wr && !inc_sec && !dec_sec;

  cal_next #(
    .SEC_LAST(SEC_LAST), .MIN_LAST(MIN_LAST), .HOUR_LAST(HOUR_LAST),
    .DOW_LAST(DOW_LAST), .MON_LAST(MON_LAST), .LEAP_LOG2(LEAP_LOG2)
  ) u_next (
    .cur(t), .nxt(adv), .hour_evt(hour_evt)
  );

  cal_dst #(.HOUR_LAST(HOUR_LAST)) u_dst (
    .clk(clk), .rst_n(rst_n), .dst_en(dst_en),
    .cfg_we(wr_en), .cfg_sel(wr_sel), .cfg_data(wr_data[DAY_W-1:0]),
    .hour_evt(hour_evt && tick_go),
    .adv_month(adv.month), .adv_day(adv.day), .adv_hour(adv.hour),
    .hour_out(hour_adj), .dst_on(dst_active)
  );

  cal_acc_mon u_acc (
    .clk(clk), .rst_n(rst_n), .tick_go(tick_go),
    .access(rd_en || wr_en), .clr(berr_clr),
    .busy(busy), .bus_err(bus_err)
  );

  always_comb begin
    nxt_t      = adv;
    nxt_t.hour = hour_adj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t <= RST_TIME;
    end else if (cnt_wr) begin
      case (sel)
        SEL_SEC:  t.sec    <= wr_data[SEC_W-1:0];
        SEL_MIN:  t.minute <= wr_data[MIN_W-1:0];
        SEL_HOUR: t.hour   <= wr_data[HOUR_W-1:0];
        SEL_DAY:  t.day    <= wr_data[DAY_W-1:0];
        SEL_DOW:  t.dow    <= wr_data[DOW_W-1:0];
        SEL_MON:  t.month  <= wr_data[MON_W-1:0];
        SEL_YEAR: t.year   <= wr_data[YEAR_W-1:0];
        default: ;
      endcase
    end else if (up_req) begin
      t.sec <= SEC_W'(step_up(int'(t.sec), SEC_LAST));
    end else if (dn_req) begin
      t.sec <= SEC_W'(step_dn(int'(t.sec), SEC_LAST));
    end else if (tick_go) begin
      t <= nxt_t;
    end
  end

  assign cnt_sec    = t.sec;
  assign cnt_minute = t.minute;
  assign cnt_hour   = t.hour;
  assign cnt_day    = t.day;
  assign cnt_dow    = t.dow;
  assign cnt_month  = t.month;
  assign cnt_year   = t.year;

  // R6
  sec_dn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_sec && !inc_sec && !wr_en && t.sec == '0) |=>
      (int'(t.sec) == SEC_LAST && $stable(t.minute)));
  // R5
  wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 4'(SEL_SEC)) |=> (t.sec == $past(wr_data[SEC_W-1:0])));
  // R10
  busy_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> $past(tick_1hz));
  // R2
  sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_1hz && !wr_en && !inc_sec && !dec_sec && int'(t.sec) < SEC_LAST) |=>
      (t.sec == $past(t.sec) + SEC_W'(1)));
endmodule

// File: tb/sim_cal_dst_clock.sv
module sim_cal_dst_clock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_1hz = 0, wr_en = 0, rd_en = 0, inc_sec = 0, dec_sec = 0, dst_en = 0, berr_clr = 0;
  logic [3:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic [5:0] cnt_sec, cnt_minute;
  logic [4:0] cnt_hour, cnt_day;
  logic [2:0] cnt_dow;
  logic [3:0] cnt_month;
  logic [7:0] cnt_year;
  logic dst_active, busy, bus_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cal_dst_clock u0 (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_en(rd_en), .inc_sec(inc_sec), .dec_sec(dec_sec),
    .dst_en(dst_en), .berr_clr(berr_clr), .cnt_sec(cnt_sec), .cnt_minute(cnt_minute),
    .cnt_hour(cnt_hour), .cnt_day(cnt_day), .cnt_dow(cnt_dow), .cnt_month(cnt_month),
    .cnt_year(cnt_year), .dst_active(dst_active), .busy(busy), .bus_err(bus_err)
  );

  // Packed as year, month, day, dow, hour, minute, second
  function automatic logic [36:0] mk(int y, int m, int d, int w, int h, int mi, int s);
    return {8'(y), 4'(m), 5'(d), 3'(w), 5'(h), 6'(mi), 6'(s)};
  endfunction

  localparam int NV = 10;
  localparam logic [36:0] VIN [NV] = '{
    mk(0,1,1,0,0,0,0),     mk(0,1,1,0,0,0,59),    mk(0,1,1,0,0,59,59),
    mk(1,1,31,6,23,59,59), mk(1,2,28,3,23,59,59), mk(4,2,28,3,23,59,59),
    mk(4,2,29,4,23,59,59), mk(9,4,30,2,23,59,59), mk(255,12,31,5,23,59,59),
    mk(7,7,30,1,23,59,59)};
  localparam logic [36:0] VOUT [NV] = '{
    mk(0,1,1,0,0,0,1),     mk(0,1,1,0,0,1,0),     mk(0,1,1,0,1,0,0),
    mk(1,2,1,0,0,0,0),     mk(1,3,1,4,0,0,0),     mk(4,2,29,4,0,0,0),
    mk(4,3,1,5,0,0,0),     mk(9,5,1,3,0,0,0),     mk(0,1,1,6,0,0,0),
    mk(7,7,31,2,0,0,0)};

  function automatic logic [36:0] obs();
    return {cnt_year, cnt_month, cnt_day, cnt_dow, cnt_hour, cnt_minute, cnt_sec};
  endfunction

  task automatic chk(input string tag, input logic [36:0] act, input logic [36:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input int sel, input int data);
    wr_en = 1; wr_sel = 4'(sel); wr_data = 8'(data);
    step();
    wr_en = 0;
  endtask

  task automatic set_time(input logic [36:0] v);
    wr(6, int'(v[36:29])); wr(5, int'(v[28:25])); wr(3, int'(v[24:20]));
    wr(4, int'(v[19:17])); wr(2, int'(v[16:12])); wr(1, int'(v[11:6]));
    wr(0, int'(v[5:0]));
  endtask

  task automatic tick();
    tick_1hz = 1; step(); tick_1hz = 0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 time", obs(), mk(0,1,1,0,0,0,0));
    chk("R1 flags", {34'b0, busy, bus_err, dst_active}, '0);

    // R2 R3 R4 table walk
    for (int i = 0; i < NV; i++) begin
      set_time(VIN[i]);
      tick();
      chk($sformatf("R2/R3/R4 vector %0d", i), obs(), VOUT[i]);
    end

    // R5 write beats tick
    set_time(mk(0,1,1,0,0,0,10));
    step();
    tick_1hz = 1; wr_en = 1; wr_sel = 4'd0; wr_data = 8'd30;
    step();
    tick_1hz = 0; wr_en = 0;
    chk("R5 write wins", obs(), mk(0,1,1,0,0,0,30));
    chk("R5 tick dropped busy", {36'b0, busy}, '0);

    // R6 strobes
    set_time(mk(0,1,1,0,0,5,59));
    inc_sec = 1; step(); inc_sec = 0;
    chk("R6 inc wrap", obs(), mk(0,1,1,0,0,5,0));
    dec_sec = 1; tick_1hz = 1; step(); dec_sec = 0; tick_1hz = 0;
    chk("R6 dec wrap", obs(), mk(0,1,1,0,0,5,59));
    inc_sec = 1; dec_sec = 1; tick_1hz = 1; step();
    inc_sec = 0; dec_sec = 0; tick_1hz = 0;
    chk("R6 both", obs(), mk(0,1,1,0,0,5,59));

    // DST configuration while disabled
    wr(7, 3); wr(8, 10); wr(9, 2); wr(10, 11); wr(11, 3); wr(12, 2);
    // R7 no shift when disabled
    set_time(mk(3,3,10,2,1,59,59)); tick();
    chk("R7 disabled", obs(), mk(3,3,10,2,2,0,0));
    dst_en = 1;
    wr(9, 5);  // R9 must be ignored: start stays at hour 2
    set_time(mk(3,3,10,2,1,59,59)); tick();
    chk("R7/R9 start shift", obs(), mk(3,3,10,2,3,0,0));
    chk("R7 active", {36'b0, dst_active}, 37'd1);
    // R8 end point
    set_time(mk(3,11,3,0,1,59,59)); tick();
    chk("R8 end shift", obs(), mk(3,11,3,0,1,0,0));
    chk("R8 inactive", {36'b0, dst_active}, '0);
    set_time(mk(3,11,3,0,1,59,59)); tick();
    chk("R8 no repeat", obs(), mk(3,11,3,0,2,0,0));
    // R9 disabling clears the flag
    set_time(mk(3,3,10,2,1,59,59)); tick();
    chk("R9 re-armed", {36'b0, dst_active}, 37'd1);
    dst_en = 0; step();
    chk("R9 cleared", {36'b0, dst_active}, '0);

    // R10 R11 busy and bus error
    berr_clr = 1; step(); berr_clr = 0;
    chk("R11 cleared", {36'b0, bus_err}, '0);
    rd_en = 1; step(); rd_en = 0;
    chk("R11 idle access", {36'b0, bus_err}, '0);
    chk("R10 idle busy", {36'b0, busy}, '0);
    tick();
    chk("R10 busy after tick", {36'b0, busy}, 37'd1);
    rd_en = 1; step(); rd_en = 0;
    chk("R11 set", {36'b0, bus_err}, 37'd1);
    chk("R10 busy one cycle", {36'b0, busy}, '0);
    step();
    chk("R11 sticky", {36'b0, bus_err}, 37'd1);
    tick();
    rd_en = 1; berr_clr = 1; step(); rd_en = 0; berr_clr = 0;
    chk("R11 set beats clear", {36'b0, bus_err}, 37'd1);
    berr_clr = 1; step(); berr_clr = 0;
    chk("R11 clear", {36'b0, bus_err}, '0);

    done = 1;
    finish_run();
  end
endmodule